// File: doc/BRIEF.md
# Bridge Gate Driver with Dead Time

This block sits between a pulse-width modulator and the gate buffers of one bridge-tied output channel. It takes two complementary PWM bits, one for each half of the bridge, and produces four gate-drive levels. Each half has a P-channel device on the supply side and an N-channel device on the ground side. The two gate polarities differ: a P-channel gate is off when high, and an N-channel gate is off when low.

Whenever a half-bridge's PWM bit changes, both of its devices are held off for a dead-time interval before the incoming device is switched on. The interval is a runtime count of clock cycles. A disable input represents the mute or sleep condition. It forces all four gates off in the same cycle it is asserted, whatever the PWM bits are. When disable is released, the outputs come back only after a full dead-time interval.

Top module: `gdrv_bridge`

## Requirements
- R1: While `rst` is high, and in the cycle after it is sampled high, all four gates are in the off state.
- R2: The off state of a half-bridge is its P-channel gate output at 1 and its N-channel gate output at 0.
- R3: Once its dead time has elapsed, a half-bridge with PWM bit 1 drives the P-channel gate to 0 and the N-channel gate to 0, so the high side is on. With PWM bit 0 it drives the P-channel gate to 1 and the N-channel gate to 1, so the low side is on. Bit 0 of `pwm` controls the positive half and bit 1 controls the negative half.
- R4: When a rising clock edge samples a PWM bit different from the one that half last accepted, that half is off from that edge onward. The incoming device turns on exactly D edges later, where D is the effective dead time.
- R5: A `dead_cyc` value of 0 acts as a dead time of one cycle.
- R6: If the PWM bit changes again before the dead-time countdown ends, the countdown restarts from the later change.
- R7: In no cycle does a half-bridge have its P-channel gate at 0 while its N-channel gate is at 1.
- R8: While `dis` is high, all four gates are off in that same cycle. No clock edge is needed.
- R9: The first rising edge that samples `dis` low starts a full dead-time interval, and outputs resume D edges after it.
- R10: The two half-bridges time their dead intervals independently. A change on one half does not disturb the other.
- R11: `dead_cyc` is captured at the edge that starts an interval. Changing it during the countdown does not alter that interval.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dis | input | 1 | Forces all gates off (mute/sleep) |
| pwm | input | 2 | PWM bits: bit 0 is the positive half, bit 1 is the negative half |
| dead_cyc | input | DT_W | Dead time in clock cycles; 0 is treated as 1 |
| pos_hi_n | output | 1 | Positive half P-channel gate (0 = on) |
| pos_lo | output | 1 | Positive half N-channel gate (1 = on) |
| neg_hi_n | output | 1 | Negative half P-channel gate (0 = on) |
| neg_lo | output | 1 | Negative half N-channel gate (1 = on) |

## Verification
The bench sweeps dead times from 0 to 6 and checks every cycle against an arithmetic count of the edges since each half's last restart. An off-by-one counter would show up as a device turning on one cycle early or late. A zero dead time that is not clamped would either leave no gap or wrap around to the longest one. The bench toggles a PWM bit back mid-countdown, changes `dead_cyc` mid-countdown, and toggles one half while the other is held. These expose a counter that is not restarted, a count that is not latched, and halves that share state. It also asserts and releases `dis` while the PWM bits are busy. A design that forced off through a register would leak one cycle of drive. A design that resumed straight from disable would switch on without a gap.

// File: rtl/gdrv_pkg.sv
package gdrv_pkg;

    // Gate levels for one half-bridge, as the gate buffers see them
    typedef struct packed {
        logic p_gate_n;   // supply-side P-channel: 0 = conducting
        logic n_gate;     // ground-side N-channel: 1 = conducting
    } gate_pair_t;

    localparam gate_pair_t GATES_OFF = '{p_gate_n: 1'b1, n_gate: 1'b0};

    typedef enum logic [1:0] {
        HB_OFF  = 2'd0,
        HB_HIGH = 2'd1,
        HB_LOW  = 2'd2
    } hb_state_t;

    function automatic gate_pair_t drive_gates(hb_state_t s);
        gate_pair_t g;
        case (s)
            HB_HIGH: g = '{p_gate_n: 1'b0, n_gate: 1'b0};
            HB_LOW:  g = '{p_gate_n: 1'b1, n_gate: 1'b1};
            default: g = GATES_OFF;
        endcase
        return g;
    endfunction

    // Zero dead time is never allowed: clamp to one cycle
    function automatic int unsigned eff_cycles(int unsigned v);
        return (v == 0) ? 1 : v;
    endfunction

endpackage

// File: rtl/gdrv_half.sv
module gdrv_half
    import gdrv_pkg::*;
#(
    parameter int DT_W = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            hold,
    input  logic            pwm,
    input  logic [DT_W-1:0] dt,
    output hb_state_t       state
);

    logic            tgt;       // level last accepted
    logic            pend;      // an interval must start at next free edge
    logic            on;
    logic [DT_W-1:0] cnt;
    logic [DT_W-1:0] dt_eff;

    assign dt_eff = DT_W'(eff_cycles(32'(dt)));

    always_ff @(posedge clk) begin
        if (rst || hold) begin
            pend <= 1'b1;
            on   <= 1'b0;
            cnt  <= '0;
            tgt  <= pwm;
        end else if (pend || (pwm != tgt)) begin
            pend <= 1'b0;
            tgt  <= pwm;
            on   <= 1'b0;
            cnt  <= dt_eff;
        end else if (!on) begin
            if (cnt <= DT_W'(1)) begin
                on  <= 1'b1;
                cnt <= '0;
            end else begin
                cnt <= cnt - DT_W'(1);
            end
        end
    end

    always_comb begin
        if (!on)      state = HB_OFF;
        else if (tgt) state = HB_HIGH;
        else          state = HB_LOW;
    end

endmodule

// File: rtl/gdrv_safe.sv
module gdrv_safe
    import gdrv_pkg::*;
#(
    parameter int NHB = 2
) (
    input  logic                  dis,
    input  hb_state_t [NHB-1:0]   st,
    output gate_pair_t [NHB-1:0]  gates
);

    for (genvar i = 0; i < NHB; i++) begin : g_force
        assign gates[i] = dis ? GATES_OFF : drive_gates(st[i]);
    end

endmodule

// File: rtl/gdrv_bridge.sv
module gdrv_bridge
    import gdrv_pkg::*;
#(
    parameter int DT_W = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            dis,
    input  logic [1:0]      pwm,
    input  logic [DT_W-1:0] dead_cyc,
    output logic            pos_hi_n,
    output logic            pos_lo,
    output logic            neg_hi_n,
    output logic            neg_lo
);

    localparam int NHB = 2;

    hb_state_t  [NHB-1:0] hb_st;
    gate_pair_t [NHB-1:0] hb_g;

    for (genvar i = 0; i < NHB; i++) begin : g_half
        gdrv_half #(.DT_W(DT_W)) u_half (
            .clk   (clk),
            .rst   (rst),
            .hold  (dis),
            .pwm   (pwm[i]),
            .dt    (dead_cyc),
            .state (hb_st[i])
        );
    end

    gdrv_safe #(.NHB(NHB)) u_safe (
        .dis   (dis),
        .st    (hb_st),
        .gates (hb_g)
    );

    assign pos_hi_n = hb_g[0].p_gate_n;
    assign pos_lo   = hb_g[0].n_gate;
    assign neg_hi_n = hb_g[1].p_gate_n;
    assign neg_lo   = hb_g[1].n_gate;

endmodule

// File: rtl/gdrv_bridge_chk.sv
module gdrv_bridge_chk (
    input logic clk,
    input logic rst,
    input logic dis,
    input logic pos_hi_n,
    input logic pos_lo,
    input logic neg_hi_n,
    input logic neg_lo
);

    logic all_off;
    assign all_off = pos_hi_n && !pos_lo && neg_hi_n && !neg_lo;

    assert_reset_off_R1: assert property (@(posedge clk)
        rst |=> all_off);

    assert_no_shoot_pos_R7: assert property (@(posedge clk) disable iff (rst)
        !(!pos_hi_n && pos_lo));

    assert_no_shoot_neg_R7: assert property (@(posedge clk) disable iff (rst)
        !(!neg_hi_n && neg_lo));

    assert_dis_forces_off_R8: assert property (@(posedge clk) disable iff (rst)
        dis |-> all_off);

    assert_gap_pos_hi_lo_R4: assert property (@(posedge clk) disable iff (rst)
        !pos_hi_n |=> !pos_lo);

    assert_gap_pos_lo_hi_R4: assert property (@(posedge clk) disable iff (rst)
        pos_lo |=> pos_hi_n);

    assert_gap_neg_R4: assert property (@(posedge clk) disable iff (rst)
        (!neg_hi_n |=> !neg_lo) and (neg_lo |=> neg_hi_n));

    assert_release_gap_R9: assert property (@(posedge clk) disable iff (rst)
        $fell(dis) |=> all_off);

endmodule

bind gdrv_bridge gdrv_bridge_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .dis      (dis),
    .pos_hi_n (pos_hi_n),
    .pos_lo   (pos_lo),
    .neg_hi_n (neg_hi_n),
    .neg_lo   (neg_lo)
);

// File: tb/sim_gdrv_bridge.sv
`timescale 1ns/1ps
module sim_gdrv_bridge;

    localparam int DT_W = 4;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            dis = 1'b0;
    logic [1:0]      pwm = 2'b00;
    logic [DT_W-1:0] dead_cyc = '0;
    logic            pos_hi_n, pos_lo, neg_hi_n, neg_lo;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // Bench model: edges since each half's last restart
    int since [2];
    bit pend  [2];
    bit last  [2];
    int deff  [2];

    always #2.5 clk = ~clk;

    gdrv_bridge #(.DT_W(DT_W)) u0 (
        .clk(clk), .rst(rst), .dis(dis), .pwm(pwm), .dead_cyc(dead_cyc),
        .pos_hi_n(pos_hi_n), .pos_lo(pos_lo), .neg_hi_n(neg_hi_n), .neg_lo(neg_lo)
    );

    task automatic check(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    // One clock: drive away from the edge, model the edge, sample after it
    task automatic step(string tag, bit r, bit d, bit [1:0] p, int dt);
        @(negedge clk);
        rst = r; dis = d; pwm = p; dead_cyc = DT_W'(dt);
        @(posedge clk);
        for (int h = 0; h < 2; h++) begin
            if (r || d) begin
                pend[h] = 1; since[h] = 0; last[h] = p[h];
            end else if (pend[h] || (p[h] != last[h])) begin
                pend[h] = 0; last[h] = p[h]; since[h] = 0;
                deff[h] = (dt == 0) ? 1 : dt;
            end else begin
                since[h]++;
            end
        end
        #1;
        for (int h = 0; h < 2; h++) begin
            bit on;
            int ep, en, ap, an;
            on = !r && !d && !pend[h] && (since[h] >= deff[h]);
            ep = (on && last[h]) ? 0 : 1;
            en = (on && !last[h]) ? 1 : 0;
            ap = (h == 0) ? int'(pos_hi_n) : int'(neg_hi_n);
            an = (h == 0) ? int'(pos_lo)   : int'(neg_lo);
            check(tag, (h == 0) ? "pos gates" : "neg gates", ap * 2 + an, ep * 2 + en);
            check("R7", "no shoot-through", int'(ap == 0 && an == 1), 0);
        end
    endtask

    task automatic hold_for(string tag, int n, bit [1:0] p, int dt);
        for (int i = 0; i < n; i++) step(tag, 0, 0, p, dt);
    endtask

    initial begin
        #500000;
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        for (int h = 0; h < 2; h++) begin pend[h] = 1; since[h] = 0; last[h] = 0; deff[h] = 1; end

        // R1 / R2: reset holds every gate off
        for (int i = 0; i < 3; i++) step("R1", 1, 0, 2'b01, 3);
        // R3: steady levels after the first interval
        hold_for("R3", 6, 2'b01, 3);
        hold_for("R3", 6, 2'b10, 3);

        // R4: sweep dead time, alternate halves
        for (int d = 1; d <= 6; d++) begin
            hold_for("R4", d + 2, 2'b11, d);
            hold_for("R4", d + 2, 2'b00, d);
            hold_for("R4", d + 2, 2'b01, d);
        end

        // R5: zero acts as one cycle
        hold_for("R5", 3, 2'b10, 0);
        hold_for("R5", 3, 2'b01, 0);

        // R6: toggle back mid-countdown restarts the interval
        hold_for("R6", 8, 2'b00, 5);
        hold_for("R6", 2, 2'b01, 5);
        hold_for("R6", 8, 2'b00, 5);

        // R10: one half toggles while the other stays on
        hold_for("R10", 6, 2'b10, 3);
        hold_for("R10", 6, 2'b00, 3);

        // R11: count latched at interval start
        hold_for("R11", 1, 2'b11, 6);
        hold_for("R11", 8, 2'b11, 1);

        // R8 / R2: disable forces off during activity
        for (int i = 0; i < 4; i++) step("R8", 0, 1, 2'(i), 2);
        step("R2", 0, 1, 2'b01, 2);
        // R9: release restarts a full interval
        hold_for("R9", 7, 2'b01, 4);
        step("R8", 0, 1, 2'b10, 4);
        hold_for("R9", 4, 2'b10, 1);

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule